// File: doc/BRIEF.md
# Multi-select SPI master sequencer

This block is a SPI master that carries out transfer messages one at a time. It drives one serial clock and one MOSI line, reads one MISO line, and controls up to `N_SEL` select outputs. Each select output has its own configured idle level, so any line can be active-low or active-high. A host presents a message descriptor with a valid/ready handshake. The descriptor gives the target line, the clock mode, a byte count, a deselect-at-end flag, flags that say whether TX and RX data are present, a batch-start marker, and the word-size and delay fields that validation checks. Bytes then move through separate per-byte TX and RX handshakes.

Before each message, every select line other than the target is released to its idle level. The clock is placed at the polarity that the message requests, and only after that is the target line asserted. A line that a message leaves asserted stays asserted into the next message, so one message can continue a device transaction started by another. A message that fails validation is answered with a done pulse and the error flag set, and no pin moves. Every later message is answered in the same way until a message marked as the start of a new batch arrives. A programmable divider sets the length of each clock phase in system cycles.

Top module: `spi_msel_master`

## Requirements
- R1: After reset, every select output equals its configured idle level, `sclk_o` is 0, `msg_ready_o` is 1 and `done_o` is 0.
- R2: When a valid message is accepted, all select lines other than the target return to idle in the next cycle. At most one select line is asserted at any time. While a message runs, only its target line is ever asserted.
- R3: `sclk_o` settles at CPOL at least one cycle before the target line is asserted. It returns to CPOL after every bit and holds that level after the message ends.
- R4: Words are 8 bits and are shifted most significant bit first on MOSI and on MISO. In `msg_mode_i`, bit0 is CPHA, bit1 is CPOL, bit2 is no-select and bit3 is reserved.
- R5: With CPHA=0, MOSI is valid and MISO is sampled during the idle-level half of each bit, which comes before the active half. With CPHA=1, the active half comes first: MOSI changes as the clock goes active and MISO is sampled just before the clock returns to idle.
- R6: If `msg_has_tx_i` is 0, every byte is sent as 0xFF. If `msg_has_rx_i` is 0, `rx_valid_o` stays low for the whole message.
- R7: At the end of a message, the target line returns to idle only if `msg_deselect_i` was 1. Otherwise it stays asserted after done.
- R8: A message is rejected in any of these cases: it sets mode bit3, `msg_bits_i` is not 8, `msg_delay_i` is nonzero, `msg_sel_i` is 4 or more, or it targets a line whose `cfg_sel_en_i` bit is 0. A rejected message produces `done_o` with `err_o`=1 and no clock edge and no select change.
- R9: After a rejection, each later message with `msg_batch_start_i`=0 is also answered with an error and is not transferred. A message with `msg_batch_start_i`=1 is validated and run normally.
- R10: Each clock phase lasts max(`cfg_div_i`,1) system cycles.
- R11: `done_o` is a single-cycle pulse. A zero-length message finishes with done, no error and no clock edge. `rx_valid_o` and `rx_data_o` hold until `rx_ready_i` is high.
- R12: With the no-select bit set, the target line stays at idle for the whole message while data still moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sel_idle_i | input | N_SEL | Idle level of each select line |
| cfg_sel_en_i | input | N_SEL | Select lines that may be targeted |
| cfg_div_i | input | DIV_W | System cycles per clock phase (0 acts as 1) |
| msg_valid_i | input | 1 | Descriptor valid |
| msg_ready_o | output | 1 | Sequencer idle, descriptor taken |
| msg_sel_i | input | SEL_W | Target select index |
| msg_mode_i | input | 4 | bit0 CPHA, bit1 CPOL, bit2 no-select, bit3 reserved |
| msg_bits_i | input | 5 | Word size, must be 8 |
| msg_delay_i | input | 8 | Inter-word delay, must be 0 |
| msg_len_i | input | LEN_W | Byte count |
| msg_deselect_i | input | 1 | Release target line at end |
| msg_has_tx_i | input | 1 | TX bytes are supplied |
| msg_has_rx_i | input | 1 | RX bytes are wanted |
| msg_batch_start_i | input | 1 | First message of a batch, clears abort |
| tx_data_i | input | 8 | TX byte |
| tx_valid_i | input | 1 | TX byte valid |
| tx_ready_o | output | 1 | TX byte taken |
| rx_data_o | output | 8 | RX byte |
| rx_valid_o | output | 1 | RX byte valid |
| rx_ready_i | input | 1 | RX byte taken |
| done_o | output | 1 | Message finished (pulse) |
| err_o | output | 1 | With done: message rejected or aborted |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| sel_o | output | N_SEL | Select lines |

## Verification
The hardest case to reach is a rejection that happens while a select line is still held asserted from an earlier message. Only in that state does "no select change" on a rejection say anything. The stimulus first runs a transfer with the deselect flag clear, then sends each of the five rejected descriptor kinds, then checks the clock edge count and the select pins each time. The batch sequence places a well-formed message without the batch-start marker right after a rejection, to show it is dropped. It then sends the same message with the marker set, to show the abort ends there.

// File: rtl/spi_msel_pkg.sv
`timescale 1ns/1ps
package spi_msel_pkg;
  localparam int WORD_W  = 8;
  localparam int MODE_W  = 4;
  localparam int BITS_W  = 5;
  localparam int DLY_W   = 8;
  localparam int CPHA_B  = 0;
  localparam int CPOL_B  = 1;
  localparam int NOSEL_B = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOAD, ST_PH_A, ST_PH_B, ST_RXOUT, ST_FINISH
  } seq_st_e;
endpackage

// File: rtl/spi_msel_check.sv
`timescale 1ns/1ps
module spi_msel_check
  import spi_msel_pkg::*;
#(
  parameter int N_SEL = 4,
  parameter int SEL_W = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [SEL_W-1:0]  idx_i,
  input  logic [N_SEL-1:0]  en_i,
  output logic              bad_o
);
  localparam logic [MODE_W-1:0] MODE_OK =
    MODE_W'((1 << CPHA_B) | (1 << CPOL_B) | (1 << NOSEL_B));

  logic line_on;

  always_comb begin
    line_on = 1'b0;
    for (int i = 0; i < N_SEL; i++)
      if (idx_i == SEL_W'(i)) line_on = en_i[i];
  end

  assign bad_o = (|(mode_i & ~MODE_OK))
               | (bits_i != BITS_W'(WORD_W))
               | (dly_i != '0)
               | (idx_i >= SEL_W'(N_SEL))
               | !line_on;
endmodule

// File: rtl/spi_msel_tick.sv
`timescale 1ns/1ps
module spi_msel_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // phase counter never passes its limit while the divider is held
  assert_phase_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $stable(div_i)) |-> (cnt_q <= lim));
endmodule

// File: rtl/spi_msel_shift.sv
`timescale 1ns/1ps
module spi_msel_shift
  import spi_msel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              sample_i,
  input  logic              miso_i,
  input  logic              shift_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_o
);
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)       tx_q <= load_data_i;
      else if (shift_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      if (load_i)        rx_q <= '0;
      else if (sample_i) rx_q <= {rx_q[WORD_W-2:0], miso_i};
    end
  end

  assign mosi_o = tx_q[WORD_W-1];
  assign rx_o   = rx_q;

  assert_msb_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> (rx_o[0] == $past(miso_i)));
endmodule

// File: rtl/spi_msel_master.sv
`timescale 1ns/1ps
module spi_msel_master
  import spi_msel_pkg::*;
#(
  parameter int N_SEL = 4,
  parameter int DIV_W = 8,
  parameter int LEN_W = 8,
  localparam int SEL_W = $clog2(N_SEL) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SEL-1:0]  cfg_sel_idle_i,
  input  logic [N_SEL-1:0]  cfg_sel_en_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic              msg_valid_i,
  output logic              msg_ready_o,
  input  logic [SEL_W-1:0]  msg_sel_i,
  input  logic [3:0]        msg_mode_i,
  input  logic [4:0]        msg_bits_i,
  input  logic [7:0]        msg_delay_i,
  input  logic [LEN_W-1:0]  msg_len_i,
  input  logic              msg_deselect_i,
  input  logic              msg_has_tx_i,
  input  logic              msg_has_rx_i,
  input  logic              msg_batch_start_i,
  input  logic [7:0]        tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              done_o,
  output logic              err_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [N_SEL-1:0]  sel_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  seq_st_e           state_q;
  logic [N_SEL-1:0]  act_q;
  logic [N_SEL-1:0]  hit_new, hit_q;
  logic [SEL_W-1:0]  idx_q;
  logic [LEN_W-1:0]  left_q;
  logic [BIT_W-1:0]  bit_q;
  logic cpol_q, cpha_q, nosel_q, desel_q, htx_q, hrx_q, err_q, abort_q;
  logic bad, tick, in_a, in_b, load, skip;

  for (genvar g = 0; g < N_SEL; g++) begin : g_hit
    assign hit_new[g] = (msg_sel_i == SEL_W'(g));
    assign hit_q[g]   = (idx_q == SEL_W'(g));
  end

  spi_msel_check #(.N_SEL(N_SEL), .SEL_W(SEL_W)) u_check (
    .mode_i(msg_mode_i), .bits_i(msg_bits_i), .dly_i(msg_delay_i),
    .idx_i(msg_sel_i), .en_i(cfg_sel_en_i), .bad_o(bad)
  );

  assign in_a = (state_q == ST_PH_A);
  assign in_b = (state_q == ST_PH_B);

  spi_msel_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(in_a | in_b),
    .div_i(cfg_div_i), .tick_o(tick)
  );

  assign load = (state_q == ST_LOAD) && (!htx_q || tx_valid_i);

  spi_msel_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .load_data_i(htx_q ? tx_data_i : '1),
    .sample_i(in_a && tick), .miso_i(miso_i), .shift_i(in_b && tick),
    .mosi_o(mosi_o), .rx_o(rx_data_o)
  );

  assign skip        = abort_q && !msg_batch_start_i;
  assign msg_ready_o = (state_q == ST_IDLE);
  assign tx_ready_o  = (state_q == ST_LOAD) && htx_q;
  assign rx_valid_o  = (state_q == ST_RXOUT);
  assign done_o      = (state_q == ST_FINISH);
  assign err_o       = done_o && err_q;
  // phase A is idle-level for CPHA=0, active-level for CPHA=1
  assign sclk_o      = cpol_q ^ ((cpha_q & in_a) | (~cpha_q & in_b));
  assign sel_o       = cfg_sel_idle_i ^ act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      idx_q   <= '0;
      left_q  <= '0;
      bit_q   <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      nosel_q <= 1'b0;
      desel_q <= 1'b0;
      htx_q   <= 1'b0;
      hrx_q   <= 1'b0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (msg_valid_i) begin
          if (skip || bad) begin
            err_q   <= 1'b1;
            abort_q <= 1'b1;
            state_q <= ST_FINISH;
          end else begin
            err_q   <= 1'b0;
            abort_q <= 1'b0;
            idx_q   <= msg_sel_i;
            cpol_q  <= msg_mode_i[CPOL_B];
            cpha_q  <= msg_mode_i[CPHA_B];
            nosel_q <= msg_mode_i[NOSEL_B];
            desel_q <= msg_deselect_i;
            htx_q   <= msg_has_tx_i;
            hrx_q   <= msg_has_rx_i;
            left_q  <= msg_len_i;
            act_q   <= act_q & hit_new;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          act_q   <= nosel_q ? (act_q & ~hit_q) : (act_q | hit_q);
          state_q <= (left_q == '0) ? ST_FINISH : ST_LOAD;
        end
        ST_LOAD: if (load) begin
          bit_q   <= '0;
          state_q <= ST_PH_A;
        end
        ST_PH_A: if (tick) state_q <= ST_PH_B;
        ST_PH_B: if (tick) begin
          bit_q <= bit_q + 1'b1;
          if (bit_q != BIT_LAST) begin
            state_q <= ST_PH_A;
          end else if (hrx_q) begin
            state_q <= ST_RXOUT;
          end else begin
            left_q  <= left_q - 1'b1;
            state_q <= (left_q == LEN_W'(1)) ? ST_FINISH : ST_LOAD;
          end
        end
        ST_RXOUT: if (rx_ready_i) begin
          left_q  <= left_q - 1'b1;
          state_q <= (left_q == LEN_W'(1)) ? ST_FINISH : ST_LOAD;
        end
        ST_FINISH: begin
          if (!err_q && desel_q) act_q <= act_q & ~hit_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_clk_idle_before_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_q & ~$past(act_q)) != '0) |-> ($past(sclk_o) == cpol_q));

  assert_single_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_q));

  assert_reject_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_q) |-> ($stable(act_q) && $stable(sclk_o)));

  assert_rx_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_rx_when_unwanted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hrx_q && !msg_ready_o) |-> !rx_valid_o);

  assert_nosel_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((in_a || in_b) && nosel_q) |-> ((act_q & hit_q) == '0));
endmodule

// File: tb/spi_msel_master_tb_top.sv
`timescale 1ns/1ps
module spi_msel_master_tb_top;
  localparam int N_SEL = 4;
  localparam int DIV_W = 8;
  localparam int LEN_W = 8;
  localparam int SEL_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N_SEL-1:0] idle = 4'b0001;
  logic [N_SEL-1:0] en   = 4'b0111;
  logic [DIV_W-1:0] div  = 8'd1;
  logic msg_valid = 0, msg_ready;
  logic [SEL_W-1:0] msg_sel = '0;
  logic [3:0] msg_mode = '0;
  logic [4:0] msg_bits = 5'd8;
  logic [7:0] msg_dly = '0;
  logic [LEN_W-1:0] msg_len = '0;
  logic msg_desel = 0, msg_htx = 0, msg_hrx = 0, msg_bstart = 0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 0, tx_ready;
  logic [7:0] rx_data;
  logic rx_valid, rx_ready = 0;
  logic done, err, sclk, mosi;
  logic miso = 0;
  logic [N_SEL-1:0] sel;

  spi_msel_master #(.N_SEL(N_SEL), .DIV_W(DIV_W), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_sel_idle_i(idle), .cfg_sel_en_i(en),
    .cfg_div_i(div), .msg_valid_i(msg_valid), .msg_ready_o(msg_ready),
    .msg_sel_i(msg_sel), .msg_mode_i(msg_mode), .msg_bits_i(msg_bits),
    .msg_delay_i(msg_dly), .msg_len_i(msg_len), .msg_deselect_i(msg_desel),
    .msg_has_tx_i(msg_htx), .msg_has_rx_i(msg_hrx), .msg_batch_start_i(msg_bstart),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .done_o(done), .err_o(err), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .sel_o(sel)
  );

  int total = 0, bad = 0;
  logic fin = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model
  logic [7:0] slv_out[4];
  logic [7:0] got[4];
  logic [7:0] tx_bytes[4];
  logic [7:0] rx_got[4];
  int s_bit = 0;
  logic s_on = 0, s_cpol = 0, s_cpha = 0;

  function automatic logic out_bit(input int b);
    if (b >= 32) return 1'b0;
    return slv_out[b/8][7-(b%8)];
  endfunction

  always @(sclk) begin
    if (s_on) begin
      if (sclk != s_cpol) begin
        if (!s_cpha) begin
          if (s_bit < 32) got[s_bit/8][7-(s_bit%8)] = mosi;
        end else miso = out_bit(s_bit);
      end else begin
        if (s_cpha) begin
          if (s_bit < 32) got[s_bit/8][7-(s_bit%8)] = mosi;
          s_bit++;
        end else begin
          s_bit++;
          miso = out_bit(s_bit);
        end
      end
    end
  end

  // monitors
  int sclk_changes = 0;
  int run_len = 0, run_min = 999, run_max = 0, rx_seen = 0;
  logic [N_SEL-1:0] act_seen = '0;
  always @(sclk) sclk_changes++;
  always @(negedge clk) begin
    if (s_on) begin
      act_seen = act_seen | (sel ^ idle);
      if (sclk != s_cpol) run_len++;
      else if (run_len != 0) begin
        if (run_len < run_min) run_min = run_len;
        if (run_len > run_max) run_max = run_len;
        run_len = 0;
      end
      if (rx_valid) rx_seen++;
    end
  end

  logic res_err, sclk_setup, done_after;
  logic [N_SEL-1:0] sel_setup;

  task automatic send(input int idx, input logic [3:0] mode, input int len,
                      input logic desel, input logic htx, input logic hrx,
                      input logic bstart, input int bits, input int dly,
                      input logic exp_err);
    s_cpol = mode[1]; s_cpha = mode[0]; s_bit = 0; miso = slv_out[0][7];
    run_min = 999; run_max = 0; run_len = 0; rx_seen = 0; act_seen = '0;
    for (int i = 0; i < 4; i++) begin got[i] = '0; rx_got[i] = '0; end
    @(negedge clk);
    msg_sel = SEL_W'(idx); msg_mode = mode; msg_len = LEN_W'(len);
    msg_desel = desel; msg_htx = htx; msg_hrx = hrx; msg_bstart = bstart;
    msg_bits = 5'(bits); msg_dly = 8'(dly); msg_valid = 1;
    @(negedge clk);
    msg_valid = 0;
    sel_setup = sel; sclk_setup = sclk;
    if (!exp_err) begin
      s_on = 1;
      for (int b = 0; b < len; b++) begin
        if (htx) begin
          tx_data = tx_bytes[b]; tx_valid = 1;
          while (!tx_ready) @(negedge clk);
          @(negedge clk);
          tx_valid = 0;
        end
        if (hrx) begin
          while (!rx_valid) @(negedge clk);
          rx_got[b] = rx_data; rx_ready = 1;
          @(negedge clk);
          rx_ready = 0;
        end
      end
    end
    while (!done) @(negedge clk);
    res_err = err;
    s_on = 0;
    @(negedge clk);
    done_after = done;
  endtask

  task automatic t_reset;
    chk(sel == idle, "R1", "sel after reset", sel, idle);
    chk(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    chk(msg_ready == 1'b1, "R1", "ready after reset", msg_ready, 1);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
  endtask

  task automatic t_mode0;
    div = 8'd1;
    tx_bytes[0] = 8'hA5; tx_bytes[1] = 8'h3C;
    slv_out[0] = 8'h5A; slv_out[1] = 8'hC3;
    send(0, 4'b0000, 2, 0, 1, 1, 1, 8, 0, 0);
    chk(res_err == 0, "R8", "mode0 err", res_err, 0);
    chk(got[0] == 8'hA5 && got[1] == 8'h3C, "R4", "mode0 mosi",
        {got[0], got[1]}, 16'hA53C);
    chk(rx_got[0] == 8'h5A && rx_got[1] == 8'hC3, "R5", "mode0 miso",
        {rx_got[0], rx_got[1]}, 16'h5AC3);
    chk(run_min == 1 && run_max == 1, "R10", "mode0 phase len", run_max, 1);
    chk(sel == (idle ^ 4'b0001), "R7", "line kept after no-deselect", sel, idle ^ 4'b0001);
    chk(done_after == 0, "R11", "done single pulse", done_after, 0);
    chk(act_seen == 4'b0001, "R2", "only target asserted", act_seen, 4'b0001);
  endtask

  task automatic t_mode3;
    div = 8'd3;
    tx_bytes[0] = 8'h96; slv_out[0] = 8'h69;
    send(1, 4'b0011, 1, 1, 1, 1, 1, 8, 0, 0);
    chk(sel_setup == idle, "R2", "others idle before assert", sel_setup, idle);
    chk(sclk_setup == 1'b1, "R3", "clock at cpol before select", sclk_setup, 1);
    chk(got[0] == 8'h96, "R4", "mode3 mosi", got[0], 8'h96);
    chk(rx_got[0] == 8'h69, "R5", "mode3 miso", rx_got[0], 8'h69);
    chk(run_min == 3 && run_max == 3, "R10", "div3 phase len", run_max, 3);
    chk(sel == idle, "R7", "deselect at end", sel, idle);
    chk(sclk == 1'b1, "R3", "clock idle after message", sclk, 1);
  endtask

  task automatic t_mode1_mode2;
    div = 8'd2;
    tx_bytes[0] = 8'hC1; slv_out[0] = 8'h1C;
    send(2, 4'b0001, 1, 1, 1, 1, 1, 8, 0, 0);
    chk(got[0] == 8'hC1 && rx_got[0] == 8'h1C, "R5", "mode1 data",
        {got[0], rx_got[0]}, 16'hC11C);
    chk(run_max == 2, "R10", "div2 phase len", run_max, 2);
    div = 8'd0;
    tx_bytes[0] = 8'h0F; slv_out[0] = 8'hF0;
    send(2, 4'b0010, 1, 1, 1, 1, 1, 8, 0, 0);
    chk(got[0] == 8'h0F && rx_got[0] == 8'hF0, "R5", "mode2 data",
        {got[0], rx_got[0]}, 16'h0FF0);
    chk(run_min == 1 && run_max == 1, "R10", "div0 acts as 1", run_max, 1);
    chk(sclk == 1'b1, "R3", "mode2 clock idle high", sclk, 1);
  endtask

  task automatic t_defaults;
    div = 8'd1;
    slv_out[0] = 8'h00; slv_out[1] = 8'h00;
    send(0, 4'b0000, 2, 1, 0, 0, 1, 8, 0, 0);
    chk(got[0] == 8'hFF && got[1] == 8'hFF, "R6", "fill ones", {got[0], got[1]}, 16'hFFFF);
    chk(rx_seen == 0, "R6", "no rx strobes", rx_seen, 0);
  endtask

  task automatic t_nosel;
    tx_bytes[0] = 8'h55; slv_out[0] = 8'hAA;
    send(1, 4'b0100, 1, 0, 1, 1, 1, 8, 0, 0);
    chk(act_seen == '0, "R12", "no-select keeps line idle", act_seen, 0);
    chk(got[0] == 8'h55 && rx_got[0] == 8'hAA, "R12", "no-select data",
        {got[0], rx_got[0]}, 16'h55AA);
  endtask

  task automatic t_len0;
    int c0;
    c0 = sclk_changes;
    send(2, 4'b0000, 0, 1, 1, 1, 1, 8, 0, 0);
    chk(res_err == 0, "R11", "empty message no error", res_err, 0);
    chk(sclk_changes == c0, "R11", "empty message no clock", sclk_changes, c0);
  endtask

  task automatic rej(input int idx, input logic [3:0] mode, input int bits,
                     input int dly, input string what);
    int c0;
    logic [N_SEL-1:0] s0;
    c0 = sclk_changes; s0 = sel;
    send(idx, mode, 1, 1, 1, 1, 1, bits, dly, 1);
    chk(res_err == 1, "R8", what, res_err, 1);
    chk(sclk_changes == c0, "R8", what, sclk_changes, c0);
    chk(sel == s0, "R8", what, sel, s0);
  endtask

  task automatic t_reject;
    tx_bytes[0] = 8'h11; slv_out[0] = 8'h22;
    send(0, 4'b0000, 1, 0, 1, 1, 1, 8, 0, 0);
    rej(0, 4'b1000, 8, 0, "reserved mode bit");
    rej(0, 4'b0000, 7, 0, "word size");
    rej(0, 4'b0000, 8, 3, "delay");
    rej(4, 4'b0000, 8, 0, "index range");
    rej(3, 4'b0000, 8, 0, "disabled line");
  endtask

  task automatic t_batch;
    int c0;
    send(2, 4'b0000, 1, 1, 1, 1, 1, 9, 0, 1);
    chk(res_err == 1, "R9", "batch head rejected", res_err, 1);
    c0 = sclk_changes;
    send(2, 4'b0000, 1, 1, 1, 1, 0, 8, 0, 1);
    chk(res_err == 1, "R9", "follower aborted", res_err, 1);
    chk(sclk_changes == c0, "R9", "follower not clocked", sclk_changes, c0);
    tx_bytes[0] = 8'h7E; slv_out[0] = 8'hE7;
    send(2, 4'b0000, 1, 1, 1, 1, 1, 8, 0, 0);
    chk(res_err == 0, "R9", "new batch runs", res_err, 0);
    chk(got[0] == 8'h7E && rx_got[0] == 8'hE7, "R9", "new batch data",
        {got[0], rx_got[0]}, 16'h7EE7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode3();
    t_mode1_mode2();
    t_defaults();
    t_nosel();
    t_len0();
    t_reject();
    t_batch();
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule